// File: doc/BRIEF.md
# Randomized Region Translation Table

This block turns a physical block address into a memory block address for a main memory whose cells wear out under repeated writes. The address space is cut into regions of equal size. Each region owns one table entry, which holds a target region number and an XOR mask. The target region number replaces the upper address bits. The mask is XORed into the block offset inside the region. The translation is purely combinational: one table read followed by one XOR.

On every write the block samples a field of random bits. If that field is all zeros, a remap starts, so a k-bit field gives a remap probability of 2^-k per write. A remap exchanges the target regions of the written region and of a second region picked by further random bits. It also XORs fresh random values into both masks. No write counter is involved. The table updates on the clock edge that accepts the remap. A registered swap command then tells a separate data mover which regions to exchange, with their old and new mappings. The command stays up until the mover returns a done pulse, and new triggers are dropped while it is up.

Top module: `rrt_top`

## Requirements
- R1: After reset every entry maps region r to target region r with a zero mask, so `xlat_addr` equals `acc_addr`, and `swap_valid` is low.
- R2: `xlat_addr` is combinational. Its upper REGION_BITS bits are the target region of entry `acc_addr[AW-1:OFFSET_BITS]`. Its lower OFFSET_BITS bits are `acc_addr[OFFSET_BITS-1:0]` XOR that entry's mask.
- R3: A cycle with `acc_wr` low never changes the table and never raises `swap_valid`, whatever the random inputs hold.
- R4: A remap is accepted only in a cycle where `acc_wr` is high, `rnd_trig` is all zeros, and no command is pending. A write with a nonzero `rnd_trig` leaves the table unchanged.
- R5: On a remap with written region A and partner B = `rnd_region`, where A differs from B, A takes B's old target and B takes A's old target.
- R6: On a remap, A's new mask is its old mask XOR `rnd_disp_a`. When B differs from A, B's new mask is its old mask XOR `rnd_disp_b`.
- R7: When `rnd_region` equals A, A keeps its target, only `rnd_disp_a` is applied to its mask, and the command reports B's fields equal to A's.
- R8: In the cycle after a remap is accepted, `swap_valid` is high and the command carries both region numbers plus the old and new target and mask of each. The command is held unchanged until the cycle after `swap_done` is sampled high.
- R9: A trigger that arrives while `swap_valid` is high is ignored: neither the table nor the command changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_addr | input | AW | Physical block address of the access |
| acc_wr | input | 1 | High when the access is a write |
| rnd_trig | input | TRIG_BITS | Random trigger field; all zeros requests a remap |
| rnd_region | input | REGION_BITS | Random partner region number |
| rnd_disp_a | input | OFFSET_BITS | Random mask update for the written region |
| rnd_disp_b | input | OFFSET_BITS | Random mask update for the partner region |
| swap_done | input | 1 | Data mover has finished the pending exchange |
| xlat_addr | output | AW | Translated memory block address |
| swap_valid | output | 1 | Swap command pending |
| swap_a_region | output | REGION_BITS | Written region number |
| swap_b_region | output | REGION_BITS | Partner region number |
| swap_a_old_addr | output | REGION_BITS | Target of A before the remap |
| swap_a_old_disp | output | OFFSET_BITS | Mask of A before the remap |
| swap_a_new_addr | output | REGION_BITS | Target of A after the remap |
| swap_a_new_disp | output | OFFSET_BITS | Mask of A after the remap |
| swap_b_old_addr | output | REGION_BITS | Target of B before the remap |
| swap_b_old_disp | output | OFFSET_BITS | Mask of B before the remap |
| swap_b_new_addr | output | REGION_BITS | Target of B after the remap |
| swap_b_new_disp | output | OFFSET_BITS | Mask of B after the remap |

## Verification
The bench builds the block with 8 regions of 8 blocks and a 2-bit trigger field. With those values a whole table fits in a few vectors, and a trigger fires one write in four when the bench leaves it to chance. The bench also forces `rnd_trig` to zero whenever it needs a remap. A partner equal to the written region and a trigger during a pending command can then be set up in a single cycle. The bench keeps its own permutation and mask model and compares the translated address against it before and after every edge.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
  typedef enum logic {
    CMD_IDLE = 1'b0,
    CMD_PEND = 1'b1
  } cmd_state_e;
endpackage

// File: rtl/rrt_rst_sync.sv
module rrt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/rrt_table.sv
module rrt_table #(
  parameter int REGION_BITS = 10,
  parameter int OFFSET_BITS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [REGION_BITS-1:0] rd_a,
  input  logic [REGION_BITS-1:0] rd_b,
  output logic [REGION_BITS-1:0] a_addr,
  output logic [OFFSET_BITS-1:0] a_disp,
  output logic [REGION_BITS-1:0] b_addr,
  output logic [OFFSET_BITS-1:0] b_disp,
  input  logic                   upd_en,
  input  logic [REGION_BITS-1:0] new_a_addr,
  input  logic [OFFSET_BITS-1:0] new_a_disp,
  input  logic [REGION_BITS-1:0] new_b_addr,
  input  logic [OFFSET_BITS-1:0] new_b_disp
);
  localparam int NREG = 1 << REGION_BITS;

  logic [REGION_BITS-1:0] map_q  [NREG];
  logic [REGION_BITS-1:0] map_d  [NREG];
  logic [OFFSET_BITS-1:0] disp_q [NREG];
  logic [OFFSET_BITS-1:0] disp_d [NREG];

  // Partner written first so the written region wins when both indices match.
  always_comb begin
    map_d  = map_q;
    disp_d = disp_q;
    if (upd_en) begin
      map_d[rd_b]  = new_b_addr;
      disp_d[rd_b] = new_b_disp;
      map_d[rd_a]  = new_a_addr;
      disp_d[rd_a] = new_a_disp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        map_q[i]  <= REGION_BITS'(i);
        disp_q[i] <= '0;
      end
    end else if (upd_en) begin
      map_q  <= map_d;
      disp_q <= disp_d;
    end
  end

  assign a_addr = map_q[rd_a];
  assign a_disp = disp_q[rd_a];
  assign b_addr = map_q[rd_b];
  assign b_disp = disp_q[rd_b];

  // R5: after a two-region exchange the partner holds the written region's former target
  assert_partner_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && rd_a != rd_b) |=> (map_q[$past(rd_b)] == $past(a_addr)));
endmodule

// File: rtl/rrt_swap_ctl.sv
module rrt_swap_ctl
  import rrt_pkg::*;
#(
  parameter int REGION_BITS = 10,
  parameter int OFFSET_BITS = 8,
  parameter int TRIG_BITS   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_wr,
  input  logic [REGION_BITS-1:0] a_region,
  input  logic [TRIG_BITS-1:0]   rnd_trig,
  input  logic [REGION_BITS-1:0] rnd_region,
  input  logic [OFFSET_BITS-1:0] rnd_disp_a,
  input  logic [OFFSET_BITS-1:0] rnd_disp_b,
  input  logic                   swap_done,
  input  logic [REGION_BITS-1:0] a_old_addr,
  input  logic [OFFSET_BITS-1:0] a_old_disp,
  input  logic [REGION_BITS-1:0] b_old_addr,
  input  logic [OFFSET_BITS-1:0] b_old_disp,
  output logic                   upd_en,
  output logic [REGION_BITS-1:0] new_a_addr,
  output logic [OFFSET_BITS-1:0] new_a_disp,
  output logic [REGION_BITS-1:0] new_b_addr,
  output logic [OFFSET_BITS-1:0] new_b_disp,
  output logic                   cmd_valid,
  output logic [REGION_BITS-1:0] cmd_a_region,
  output logic [REGION_BITS-1:0] cmd_b_region,
  output logic [REGION_BITS-1:0] cmd_a_old_addr,
  output logic [OFFSET_BITS-1:0] cmd_a_old_disp,
  output logic [REGION_BITS-1:0] cmd_a_new_addr,
  output logic [OFFSET_BITS-1:0] cmd_a_new_disp,
  output logic [REGION_BITS-1:0] cmd_b_old_addr,
  output logic [OFFSET_BITS-1:0] cmd_b_old_disp,
  output logic [REGION_BITS-1:0] cmd_b_new_addr,
  output logic [OFFSET_BITS-1:0] cmd_b_new_disp
);
  cmd_state_e state_q, state_d;
  logic       same_region;

  assign same_region = (rnd_region == a_region);
  assign upd_en      = acc_wr && (rnd_trig == '0) && (state_q == CMD_IDLE);

  always_comb begin
    new_a_addr = same_region ? a_old_addr : b_old_addr;
    new_a_disp = a_old_disp ^ rnd_disp_a;
    new_b_addr = a_old_addr;
    new_b_disp = b_old_disp ^ rnd_disp_b;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      CMD_IDLE: if (upd_en)    state_d = CMD_PEND;
      CMD_PEND: if (swap_done) state_d = CMD_IDLE;
      default:                 state_d = CMD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CMD_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_a_region   <= '0;
      cmd_b_region   <= '0;
      cmd_a_old_addr <= '0;
      cmd_a_old_disp <= '0;
      cmd_a_new_addr <= '0;
      cmd_a_new_disp <= '0;
      cmd_b_old_addr <= '0;
      cmd_b_old_disp <= '0;
      cmd_b_new_addr <= '0;
      cmd_b_new_disp <= '0;
    end else if (upd_en) begin
      cmd_a_region   <= a_region;
      cmd_b_region   <= rnd_region;
      cmd_a_old_addr <= a_old_addr;
      cmd_a_old_disp <= a_old_disp;
      cmd_a_new_addr <= new_a_addr;
      cmd_a_new_disp <= new_a_disp;
      cmd_b_old_addr <= b_old_addr;
      cmd_b_old_disp <= b_old_disp;
      cmd_b_new_addr <= same_region ? new_a_addr : new_b_addr;
      cmd_b_new_disp <= same_region ? new_a_disp : new_b_disp;
    end
  end

  assign cmd_valid = (state_q == CMD_PEND);

  // R4: a command only appears after a write with an all-zero trigger field
  assert_fire_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> ($past(acc_wr) && $past(rnd_trig) == '0));

  // R3: a read cycle never raises the command
  assert_read_no_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_wr && !cmd_valid) |=> !cmd_valid);
endmodule

// File: rtl/rrt_top.sv
module rrt_top #(
  parameter int REGION_BITS = 10,
  parameter int OFFSET_BITS = 8,
  parameter int TRIG_BITS   = 8,
  localparam int AW         = REGION_BITS + OFFSET_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          acc_addr,
  input  logic                   acc_wr,
  input  logic [TRIG_BITS-1:0]   rnd_trig,
  input  logic [REGION_BITS-1:0] rnd_region,
  input  logic [OFFSET_BITS-1:0] rnd_disp_a,
  input  logic [OFFSET_BITS-1:0] rnd_disp_b,
  input  logic                   swap_done,
  output logic [AW-1:0]          xlat_addr,
  output logic                   swap_valid,
  output logic [REGION_BITS-1:0] swap_a_region,
  output logic [REGION_BITS-1:0] swap_b_region,
  output logic [REGION_BITS-1:0] swap_a_old_addr,
  output logic [OFFSET_BITS-1:0] swap_a_old_disp,
  output logic [REGION_BITS-1:0] swap_a_new_addr,
  output logic [OFFSET_BITS-1:0] swap_a_new_disp,
  output logic [REGION_BITS-1:0] swap_b_old_addr,
  output logic [OFFSET_BITS-1:0] swap_b_old_disp,
  output logic [REGION_BITS-1:0] swap_b_new_addr,
  output logic [OFFSET_BITS-1:0] swap_b_new_disp
);
  logic                   rst_int_n;
  logic [REGION_BITS-1:0] a_region;
  logic [OFFSET_BITS-1:0] a_offset;
  logic [REGION_BITS-1:0] a_addr, b_addr, n_a_addr, n_b_addr;
  logic [OFFSET_BITS-1:0] a_disp, b_disp, n_a_disp, n_b_disp;
  logic                   upd_en;

  assign a_region = acc_addr[AW-1:OFFSET_BITS];
  assign a_offset = acc_addr[OFFSET_BITS-1:0];

  rrt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  rrt_table #(
    .REGION_BITS (REGION_BITS),
    .OFFSET_BITS (OFFSET_BITS)
  ) u_table (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rd_a       (a_region),
    .rd_b       (rnd_region),
    .a_addr     (a_addr),
    .a_disp     (a_disp),
    .b_addr     (b_addr),
    .b_disp     (b_disp),
    .upd_en     (upd_en),
    .new_a_addr (n_a_addr),
    .new_a_disp (n_a_disp),
    .new_b_addr (n_b_addr),
    .new_b_disp (n_b_disp)
  );

  rrt_swap_ctl #(
    .REGION_BITS (REGION_BITS),
    .OFFSET_BITS (OFFSET_BITS),
    .TRIG_BITS   (TRIG_BITS)
  ) u_ctl (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .acc_wr         (acc_wr),
    .a_region       (a_region),
    .rnd_trig       (rnd_trig),
    .rnd_region     (rnd_region),
    .rnd_disp_a     (rnd_disp_a),
    .rnd_disp_b     (rnd_disp_b),
    .swap_done      (swap_done),
    .a_old_addr     (a_addr),
    .a_old_disp     (a_disp),
    .b_old_addr     (b_addr),
    .b_old_disp     (b_disp),
    .upd_en         (upd_en),
    .new_a_addr     (n_a_addr),
    .new_a_disp     (n_a_disp),
    .new_b_addr     (n_b_addr),
    .new_b_disp     (n_b_disp),
    .cmd_valid      (swap_valid),
    .cmd_a_region   (swap_a_region),
    .cmd_b_region   (swap_b_region),
    .cmd_a_old_addr (swap_a_old_addr),
    .cmd_a_old_disp (swap_a_old_disp),
    .cmd_a_new_addr (swap_a_new_addr),
    .cmd_a_new_disp (swap_a_new_disp),
    .cmd_b_old_addr (swap_b_old_addr),
    .cmd_b_old_disp (swap_b_old_disp),
    .cmd_b_new_addr (swap_b_new_addr),
    .cmd_b_new_disp (swap_b_new_disp)
  );

  assign xlat_addr = {a_addr, a_offset ^ a_disp};

  // R3: with no write and a steady address the translation cannot move
  assert_read_keeps_map_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(!acc_wr) && $stable(acc_addr)) |-> $stable(xlat_addr));

  // R5: exchanged targets cross over between the two regions
  assert_targets_cross_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(swap_valid) && swap_a_region != swap_b_region) |->
      (swap_a_new_addr == swap_b_old_addr && swap_b_new_addr == swap_a_old_addr));

  // R6: the written region's mask moves by exactly the sampled random value
  assert_mask_update_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(swap_valid) |-> (swap_a_new_disp == (swap_a_old_disp ^ $past(rnd_disp_a))));

  // R8: a pending command is held until the mover reports done
  assert_cmd_held_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (swap_valid && !swap_done) |=> (swap_valid && $stable(swap_a_region) && $stable(swap_b_region)));

  // R9: a trigger during a pending command leaves the new mapping fields untouched
  assert_retrigger_ignored_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    swap_valid |=> ($stable(swap_a_new_addr) && $stable(swap_a_new_disp) && $stable(swap_b_new_disp)));
endmodule

// File: tb/tb_rrt_top.sv
`timescale 1ns/1ps
module tb_rrt_top;
  localparam int RB   = 3;
  localparam int OB   = 3;
  localparam int TB   = 2;
  localparam int AW   = RB + OB;
  localparam int NREG = 1 << RB;
  localparam int VW   = 1 + AW + TB + RB + OB + OB + 1;
  localparam int NVEC = 14;

  // {wr, addr, trig, partner, disp_a, disp_b, done}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {1'b0, 6'o15, 2'd0, 3'd4, 3'd1, 3'd2, 1'b0},
    {1'b1, 6'o23, 2'd0, 3'd5, 3'd3, 3'd6, 1'b0},
    {1'b0, 6'o23, 2'd1, 3'd0, 3'd0, 3'd0, 1'b0},
    {1'b0, 6'o52, 2'd1, 3'd0, 3'd0, 3'd0, 1'b1},
    {1'b1, 6'o71, 2'd2, 3'd1, 3'd7, 3'd7, 1'b0},
    {1'b1, 6'o71, 2'd0, 3'd7, 3'd5, 3'd2, 1'b0},
    {1'b0, 6'o77, 2'd3, 3'd0, 3'd0, 3'd0, 1'b1},
    {1'b1, 6'o44, 2'd0, 3'd0, 3'd7, 3'd1, 1'b0},
    {1'b1, 6'o04, 2'd0, 3'd3, 3'd1, 3'd1, 1'b0},
    {1'b0, 6'o04, 2'd1, 3'd0, 3'd0, 3'd0, 1'b1},
    {1'b1, 6'o04, 2'd0, 3'd3, 3'd2, 3'd4, 1'b0},
    {1'b0, 6'o34, 2'd0, 3'd6, 3'd5, 3'd5, 1'b1},
    {1'b0, 6'o40, 2'd0, 3'd2, 3'd3, 3'd3, 1'b0},
    {1'b0, 6'o00, 2'd0, 3'd1, 3'd6, 3'd6, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] acc_addr;
  logic          acc_wr;
  logic [TB-1:0] rnd_trig;
  logic [RB-1:0] rnd_region;
  logic [OB-1:0] rnd_disp_a, rnd_disp_b;
  logic          swap_done;
  logic [AW-1:0] xlat_addr;
  logic          swap_valid;
  logic [RB-1:0] swap_a_region, swap_b_region;
  logic [RB-1:0] swap_a_old_addr, swap_a_new_addr, swap_b_old_addr, swap_b_new_addr;
  logic [OB-1:0] swap_a_old_disp, swap_a_new_disp, swap_b_old_disp, swap_b_new_disp;

  int n_chk = 0;
  int n_bad = 0;
  logic [RB-1:0] m_addr [NREG];
  logic [OB-1:0] m_disp [NREG];
  logic          m_pend;

  always #2.5 clk = ~clk;

  rrt_top #(.REGION_BITS(RB), .OFFSET_BITS(OB), .TRIG_BITS(TB)) dut (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr),
    .rnd_trig(rnd_trig), .rnd_region(rnd_region), .rnd_disp_a(rnd_disp_a),
    .rnd_disp_b(rnd_disp_b), .swap_done(swap_done), .xlat_addr(xlat_addr),
    .swap_valid(swap_valid), .swap_a_region(swap_a_region), .swap_b_region(swap_b_region),
    .swap_a_old_addr(swap_a_old_addr), .swap_a_old_disp(swap_a_old_disp),
    .swap_a_new_addr(swap_a_new_addr), .swap_a_new_disp(swap_a_new_disp),
    .swap_b_old_addr(swap_b_old_addr), .swap_b_old_disp(swap_b_old_disp),
    .swap_b_new_addr(swap_b_new_addr), .swap_b_new_disp(swap_b_new_disp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] model_xlat(input logic [AW-1:0] a);
    return {m_addr[a[AW-1:OB]], a[OB-1:0] ^ m_disp[a[AW-1:OB]]};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; acc_addr = '0; acc_wr = 1'b0; rnd_trig = '1;
    rnd_region = '0; rnd_disp_a = '0; rnd_disp_b = '0; swap_done = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      m_addr[i] = RB'(i);
      m_disp[i] = '0;
    end
    m_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Drives one cycle at the negedge, checks translation, then checks the command after the edge.
  task automatic step(input logic wr, input logic [AW-1:0] a, input logic [TB-1:0] t,
                      input logic [RB-1:0] p, input logic [OB-1:0] da, input logic [OB-1:0] db,
                      input logic dn);
    logic          fire;
    logic [RB-1:0] ra;
    logic [RB-1:0] e_aold, e_anew, e_bold, e_bnew;
    logic [OB-1:0] e_adold, e_adnew, e_bdold, e_bdnew;
    @(negedge clk);
    acc_wr = wr; acc_addr = a; rnd_trig = t; rnd_region = p;
    rnd_disp_a = da; rnd_disp_b = db; swap_done = dn;
    #1;
    chk("R2 translation", 32'(xlat_addr), 32'(model_xlat(a)));
    ra      = a[AW-1:OB];
    fire    = wr && (t == '0) && !m_pend;
    e_aold  = m_addr[ra];  e_adold = m_disp[ra];
    e_bold  = m_addr[p];   e_bdold = m_disp[p];
    e_anew  = (p == ra) ? e_aold : e_bold;
    e_adnew = e_adold ^ da;
    e_bnew  = (p == ra) ? e_anew : e_aold;
    e_bdnew = (p == ra) ? e_adnew : (e_bdold ^ db);
    @(posedge clk);
    #1;
    if (m_pend && dn) m_pend = 1'b0;
    if (fire) begin
      m_pend = 1'b1;
      m_addr[p] = e_bnew;  m_disp[p] = e_bdnew;
      m_addr[ra] = e_anew; m_disp[ra] = e_adnew;
      chk("R8 command regions", 32'({swap_a_region, swap_b_region}), 32'({ra, p}));
      chk("R8 old mapping", 32'({swap_a_old_addr, swap_a_old_disp, swap_b_old_addr, swap_b_old_disp}),
          32'({e_aold, e_adold, e_bold, e_bdold}));
      if (p == ra) chk("R7 same-region remap", 32'({swap_a_new_addr, swap_a_new_disp, swap_b_new_addr, swap_b_new_disp}),
                       32'({e_anew, e_adnew, e_bnew, e_bdnew}));
      else begin
        chk("R5 targets crossed", 32'({swap_a_new_addr, swap_b_new_addr}), 32'({e_anew, e_bnew}));
        chk("R6 masks updated", 32'({swap_a_new_disp, swap_b_new_disp}), 32'({e_adnew, e_bdnew}));
      end
    end
    chk("R8 swap_valid", 32'(swap_valid), 32'(m_pend));
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1: identity map after reset
    for (int r = 0; r < NREG; r++) begin
      acc_addr = AW'((r << OB) | 5); #1;
      chk("R1 reset identity", 32'(xlat_addr), 32'((r << OB) | 5));
    end
    chk("R1 swap_valid low", 32'(swap_valid), 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      step(VEC[v][VW-1], VEC[v][VW-2 -: AW], VEC[v][VW-2-AW -: TB], VEC[v][VW-2-AW-TB -: RB],
           VEC[v][OB+OB : OB+1], VEC[v][OB:1], VEC[v][0]);
    end

    // R3: read with zero trigger leaves map intact
    step(1'b0, 6'o26, 2'd0, 3'd1, 3'd7, 3'd7, 1'b0);
    @(negedge clk); acc_wr = 1'b0; acc_addr = 6'o26; rnd_trig = 2'd1; #1;
    chk("R3 read left map", 32'(xlat_addr), 32'(model_xlat(6'o26)));
    chk("R3 read left map partner", 32'(swap_valid), 32'd0);

    // R4: write with nonzero trigger leaves map intact
    step(1'b1, 6'o61, 2'd3, 3'd2, 3'd5, 3'd5, 1'b0);
    @(negedge clk); acc_wr = 1'b0; acc_addr = 6'o61; #1;
    chk("R4 nonzero trigger ignored", 32'(xlat_addr), 32'(model_xlat(6'o61)));
    chk("R4 no command", 32'(swap_valid), 32'd0);

    // R9: second trigger during pending is dropped
    step(1'b1, 6'o13, 2'd0, 3'd6, 3'd4, 3'd2, 1'b0);
    step(1'b1, 6'o33, 2'd0, 3'd0, 3'd7, 3'd7, 1'b0);
    @(negedge clk); acc_wr = 1'b0; acc_addr = 6'o33; #1;
    chk("R9 retrigger ignored map", 32'(xlat_addr), 32'(model_xlat(6'o33)));
    chk("R9 command kept", 32'({swap_a_region, swap_b_region}), 32'({3'd1, 3'd6}));
    step(1'b0, 6'o00, 2'd1, 3'd0, 3'd0, 3'd0, 1'b1);

    // R1: reset again restores identity
    do_reset();
    for (int r = 0; r < NREG; r++) begin
      acc_addr = AW'((r << OB) | 2); #1;
      chk("R1 re-reset identity", 32'(xlat_addr), 32'((r << OB) | 2));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule